// File: doc/BRIEF.md
# Latched-Address One-of-Eight Decoder

This block turns a three-bit binary address into a selection on one of eight output lines. An address hold stage in front of the decode lets the address be frozen: while the hold control is low the path is transparent and the outputs track the live address within the same cycle. While it is high, the outputs keep showing the address captured at the last clock edge on which the hold control was low.

Two gating inputs of opposite sense sit on the output side. One enables decoding when high and the other enables it when low. Decoding happens only when both are in their active state; otherwise every line sits at its inactive level. Several blocks can therefore be cascaded. The block also works as a one-to-eight demultiplexer: hold one gate active and drive serial data onto the other, and the data then appears only on the addressed line. An elaboration-time parameter picks whether the selected line is driven low or high.

Top module: `addr_latch_decoder`

## Requirements
- R1: With decoding enabled, the address value (bit 2 most significant) selects exactly one output line, `selOut[addrIn]`, and the other seven are inactive.
- R2: While `holdAddr` is low, the outputs follow `addrIn` combinationally in the same cycle.
- R3: While `holdAddr` is high, the outputs show the address sampled at the last rising clock edge at which `holdAddr` was low. Later changes on `addrIn` have no effect on the outputs.
- R4: While `gateN` is high, every output is at its inactive level, whatever the address or hold state.
- R5: While `gateP` is low, every output is at its inactive level, whatever the address or hold state.
- R6: With `ACTIVE_HIGH` = 0 (the default), the selected line is 0 and the inactive level is 1. With `ACTIVE_HIGH` = 1, the selected line is 1 and the inactive level is 0.
- R7: With one gate held active and data toggled on the other, the addressed line carries the data and the seven other lines stay inactive.
- R8: A synchronous reset (`rst` high at a rising edge) clears the held address to 0, so holding straight after reset with both gates active selects line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address hold register |
| rst | input | 1 | Synchronous reset, active high; clears the held address |
| addrIn | input | ADDR_W (3) | Binary address |
| holdAddr | input | 1 | 0: address path transparent; 1: held address used |
| gateP | input | 1 | Gate that enables decoding when high |
| gateN | input | 1 | Gate that enables decoding when low |
| selOut | output | 2**ADDR_W (8) | Decoded lines, polarity set by ACTIVE_HIGH |

## Verification
The only state in the block is the held address, and it shows at the ports only while `holdAddr` is high and both gates are active. A wrong capture, such as loading while holding, missing a load, or a bad reset value, appears as the wrong line selected in the first cycle after the hold is raised. The bench therefore raises the hold right after known loads and after reset, changes the address underneath the hold, and compares each cycle. Gate and polarity faults need no state to show, so they are checked in the same cycle against a reference model.

// File: rtl/addr_latch_decoder_pkg.sv
package addr_latch_decoder_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;   // capture live address at next edge
    logic useLive;    // decode from live address this cycle
    logic outEnable;  // both gates active
  } dec_ctrl_t;
endpackage

// File: rtl/addr_latch_decoder_ctrl.sv
module addr_latch_decoder_ctrl
  import addr_latch_decoder_pkg::*;
(
  input  logic      holdAddr,
  input  logic      gateP,
  input  logic      gateN,
  output dec_ctrl_t ctrl
);
  always_comb begin
    ctrl.loadAddr  = !holdAddr;
    ctrl.useLive   = !holdAddr;
    ctrl.outEnable = gateP && !gateN;
  end
endmodule

// File: rtl/addr_latch_decoder_dp.sv
module addr_latch_decoder_dp
  import addr_latch_decoder_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter bit ACTIVE_HIGH = 1'b0,
  localparam int NUM_OUT    = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addrIn,
  input  dec_ctrl_t          ctrl,
  output logic [NUM_OUT-1:0] selOut
);
  logic [ADDR_W-1:0]  heldAddr;
  logic [ADDR_W-1:0]  selAddr;
  logic [NUM_OUT-1:0] oneHot;

  always_ff @(posedge clk) begin
    if (rst)                heldAddr <= '0;
    else if (ctrl.loadAddr) heldAddr <= addrIn;
  end

  assign selAddr = ctrl.useLive ? addrIn : heldAddr;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
    assign oneHot[i] = ctrl.outEnable && (selAddr == ADDR_W'(i));
  end

  if (ACTIVE_HIGH) begin : g_pos
    assign selOut = oneHot;
  end else begin : g_neg
    assign selOut = ~oneHot;
  end
endmodule

// File: rtl/addr_latch_decoder.sv
module addr_latch_decoder
  import addr_latch_decoder_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter bit ACTIVE_HIGH = 1'b0,
  localparam int NUM_OUT    = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               holdAddr,
  input  logic               gateP,
  input  logic               gateN,
  output logic [NUM_OUT-1:0] selOut
);
  dec_ctrl_t ctrl;

  addr_latch_decoder_ctrl ctrl_i (
    .holdAddr(holdAddr), .gateP(gateP), .gateN(gateN), .ctrl(ctrl)
  );

  addr_latch_decoder_dp #(.ADDR_W(ADDR_W), .ACTIVE_HIGH(ACTIVE_HIGH)) dp_i (
    .clk(clk), .rst(rst), .addrIn(addrIn), .ctrl(ctrl), .selOut(selOut)
  );
endmodule

// File: rtl/addr_latch_decoder_chk.sv
module addr_latch_decoder_chk #(
  parameter int ADDR_W      = 3,
  parameter bit ACTIVE_HIGH = 1'b0,
  localparam int NUM_OUT    = 1 << ADDR_W
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  addrIn,
  input logic               holdAddr,
  input logic               gateP,
  input logic               gateN,
  input logic [NUM_OUT-1:0] selOut
);
  logic [NUM_OUT-1:0] actVec;
  assign actVec = ACTIVE_HIGH ? selOut : ~selOut;

  assert_gaten_off_R4: assert property (@(posedge clk) disable iff (rst)
    gateN |-> (actVec == '0));

  assert_gatep_off_R5: assert property (@(posedge clk) disable iff (rst)
    !gateP |-> (actVec == '0));

  assert_single_line_R1: assert property (@(posedge clk) disable iff (rst)
    (gateP && !gateN) |-> ($countones(actVec) == 1));

  assert_live_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (gateP && !gateN && !holdAddr) |-> actVec[addrIn]);

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (holdAddr && $past(holdAddr) && gateP && !gateN && $past(gateP) && !$past(gateN))
      |-> $stable(selOut));
endmodule

bind addr_latch_decoder addr_latch_decoder_chk #(
  .ADDR_W(ADDR_W), .ACTIVE_HIGH(ACTIVE_HIGH)
) chk_i (
  .clk(clk), .rst(rst), .addrIn(addrIn), .holdAddr(holdAddr),
  .gateP(gateP), .gateN(gateN), .selOut(selOut)
);

// File: tb/addr_latch_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_latch_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addrIn = '0;
  logic       holdAddr = 1'b0;
  logic       gateP = 1'b0;
  logic       gateN = 1'b1;
  logic [7:0] selLo, selHi;

  int checkCnt = 0;
  int failCnt  = 0;
  bit doneFlag = 1'b0;
  logic [2:0] heldModel = '0;

  always #4 clk = ~clk;  // 125 MHz

  addr_latch_decoder dut_i (
    .clk(clk), .rst(rst), .addrIn(addrIn), .holdAddr(holdAddr),
    .gateP(gateP), .gateN(gateN), .selOut(selLo)
  );
  addr_latch_decoder #(.ACTIVE_HIGH(1'b1)) dut_hi_i (
    .clk(clk), .rst(rst), .addrIn(addrIn), .holdAddr(holdAddr),
    .gateP(gateP), .gateN(gateN), .selOut(selHi)
  );

  function automatic logic [7:0] expHi(input logic [2:0] a, input logic h,
                                        input logic gp, input logic gn);
    logic [2:0] s;
    s = h ? heldModel : a;
    return (gp && !gn) ? (8'b1 << s) : 8'b0;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive one cycle, check both polarities, then advance the model
  task automatic step(input string req, input logic [2:0] a, input logic h,
                      input logic gp, input logic gn);
    logic [7:0] e;
    @(negedge clk);
    addrIn = a; holdAddr = h; gateP = gp; gateN = gn;
    #1;
    e = expHi(a, h, gp, gn);
    check({req, " active-high R6"}, selHi, e);
    check({req, " active-low R6"}, selLo, ~e);
    if (!h) heldModel = a;
  endtask

  task automatic t_reset_hold();
    @(negedge clk);
    rst = 1'b1; holdAddr = 1'b1; addrIn = 3'd6; gateP = 1'b1; gateN = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0; heldModel = '0;
    #1;
    check("R8 reset selects line0 high", selHi, 8'h01);
    check("R8 reset selects line0 low", selLo, 8'hFE);
    step("R8 held zero after reset", 3'd4, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_transparent_sweep();
    for (int g = 0; g < 4; g++)
      for (int a = 0; a < 8; a++)
        step("R1 R2 R4 R5 transparent sweep", 3'(a), 1'b0, g[0], g[1]);
  endtask

  task automatic t_hold_ignore();
    step("R2 load", 3'd5, 1'b0, 1'b1, 1'b0);
    for (int a = 0; a < 8; a++)
      step("R3 hold ignores address", 3'(7 - a), 1'b1, 1'b1, 1'b0);
    for (int g = 0; g < 4; g++)
      for (int a = 0; a < 8; a++)
        step("R3 R4 R5 held sweep", 3'(a), 1'b1, g[0], g[1]);
    step("R2 reopen", 3'd2, 1'b0, 1'b1, 1'b0);
    step("R3 hold new value", 3'd7, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_demux();
    logic [7:0] pat = 8'b1011_0010;
    for (int i = 0; i < 8; i++) begin
      step("R7 demux data on gateP", 3'd3, 1'b0, pat[i], 1'b0);
      if (pat[i]) check("R7 addressed line carries data", selHi, 8'h08);
      else        check("R7 idle when data low", selHi, 8'h00);
    end
    for (int i = 0; i < 8; i++)
      step("R7 demux data on gateN", 3'd6, 1'b1, 1'b1, pat[i]);
  endtask

  initial begin
    #(8 * 200000);
    if (!doneFlag) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    t_reset_hold();
    t_transparent_sweep();
    t_hold_ignore();
    t_demux();
    doneFlag = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule